// File: doc/BRIEF.md
# Streaming Shifted-Sub-Block Lambda Accumulator

This block forms the lambda vectors of a quasi-cyclic LDPC encoder. Each lambda vector is the product of the information part of the parity-check matrix with the information word. The information word arrives one Z-bit sub-block at a time, one base-matrix column per accepted clock. The block does not wait for the whole message. As soon as a column's sub-block is present, every base-matrix row with an entry in that column takes a circularly rotated copy of the sub-block, XORed into its accumulator. The rotation amount is that entry's stored base shift, scaled to the active expansion factor.

A frame begins with a `start` pulse, which samples the rate and length selects. The block then accepts exactly Kb valid columns, where Kb depends on the rate mode. A one-cycle `done` marks the clock edge on which the last column was absorbed. The lambda outputs then hold their final values until the next `start`. The base matrix is a small table computed inside the block, and parity derivation is left to a downstream stage.

Top module: `ldpc_lambda_acc`

## Requirements
- R1: A `start` pulse clears every lambda vector to zero and samples `rate_sel` and `z_sel` for the new frame. A valid column presented in the same cycle as `start` is not absorbed.
- R2: The expansion factor is Z = 24 + 4·`z_sel`, and `z_sel` values above 18 act as 18 (Z = 96). Input bits at positions Z and above are ignored, and lambda bits at positions Z and above always read zero.
- R3: The base table entry for rate mode r, row m (0..3) and column c is empty when (m + c + r) mod 3 = 0. Otherwise it holds base shift p = (37m + 53c + 11r + 5) mod 96.
- R4: In rate mode 1 (two-thirds, variant A), the applied shift is p mod Z. In rate modes 0, 2 and 3, it is floor(p·Z/96).
- R5: A rotated contribution with shift s has bit i (for i < Z) equal to input bit (i + s) mod Z. A shift of zero passes the sub-block unchanged.
- R6: Columns are numbered 0, 1, 2, … in order of acceptance. Each accepted column is XORed, after rotation, into every row with a non-empty entry in that column, and idle cycles between columns do not disturb the accumulation.
- R7: Kb is 4, 8, 12 and 20 for rate modes 0, 1, 2 and 3. `done` is high for exactly one cycle, on the edge that absorbs column Kb−1. At that point the lambda outputs are final.
- R8: `in_valid` before the first `start` or after a frame's Kb columns has no effect, and the lambda outputs hold their values.
- R9: A `start` in the middle of a frame abandons that frame, and the new frame is computed as if the old one had never begun.
- R10: After reset, every lambda bit and `done` are zero and no frame is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a frame, clears lambdas, samples selects |
| rate_sel | input | 2 | Rate mode: 0 half, 1 two-thirds A, 2 three-quarter, 3 five-sixth |
| z_sel | input | 5 | Expansion factor select, Z = 24 + 4·z_sel |
| in_valid | input | 1 | Qualifies `in_data` as the next column's sub-block |
| in_data | input | Z_MAX | Information sub-block, bit 0 first, low Z bits used |
| lambda_out | output | MB·Z_MAX | Row m lambda in bits [m·Z_MAX +: Z_MAX] |
| done | output | 1 | One-cycle pulse when the last column is absorbed |

## Verification
Frames are run in every rate mode at smallest, middle and largest expansion factors, each with its own pseudo-random column data. A rate-mode-1 frame at Z = 52 separates modulo scaling from proportional scaling, because the two give different shifts there. Full-width Z = 96 frames expose rotation direction errors, and Z = 24 frames with dirty high input bits expose missing masking. Gapped valid strobes, an aborted frame followed by a fresh one, an out-of-range length select, and strobes outside a frame test the column counting, restart behaviour and ignore behaviour.

// File: rtl/ldpc_lambda_pkg.sv
package ldpc_lambda_pkg;

    localparam int Z_MAX_DEF  = 96;
    localparam int MB_DEF     = 4;
    localparam int KB_MAX_DEF = 20;
    localparam int Z_MIN      = 24;
    localparam int Z_STEP     = 4;
    localparam int Z_SEL_TOP  = 18;
    localparam int P_BASE     = 96;
    localparam int PW         = 7;

    typedef enum logic [1:0] {
        RATE_HALF   = 2'd0,
        RATE_TWO3_A = 2'd1,
        RATE_THREE4 = 2'd2,
        RATE_FIVE6  = 2'd3
    } rate_e;

    typedef struct packed {
        logic          present;
        logic [PW-1:0] p;
    } base_ent_t;

    function automatic base_ent_t base_lookup(rate_e r, int row, int col);
        base_ent_t e;
        e.present = ((row + col + int'(r)) % 3) != 0;
        e.p       = PW'((row * 37 + col * 53 + int'(r) * 11 + 5) % P_BASE);
        return e;
    endfunction

    function automatic int kb_of(rate_e r);
        case (r)
            RATE_HALF:   return 4;
            RATE_TWO3_A: return 8;
            RATE_THREE4: return 12;
            default:     return 20;
        endcase
    endfunction

    function automatic logic [PW-1:0] z_of(logic [4:0] sel);
        int s;
        s = (int'(sel) > Z_SEL_TOP) ? Z_SEL_TOP : int'(sel);
        return PW'(Z_MIN + Z_STEP * s);
    endfunction

endpackage

// File: rtl/ldpc_shift_scale.sv
module ldpc_shift_scale
    import ldpc_lambda_pkg::*;
#(
    parameter int ZW = 7
) (
    input  logic [PW-1:0] p,
    input  logic [ZW-1:0] z,
    input  logic          mod_mode,
    output logic [ZW-1:0] s
);
    localparam int PRW = PW + ZW;

    logic [PRW-1:0] prod;
    logic [PRW-1:0] quot;
    logic [ZW-1:0]  rem;

    always_comb begin
        prod = PRW'(p) * PRW'(z);
        quot = prod / PRW'(P_BASE);
        rem  = (z != '0) ? ZW'(ZW'(p) % z) : '0;
        s    = mod_mode ? rem : ZW'(quot);
    end
endmodule

// File: rtl/ldpc_rotor.sv
module ldpc_rotor #(
    parameter int Z_MAX = 96,
    parameter int ZW    = 7
) (
    input  logic [Z_MAX-1:0] x,
    input  logic [ZW-1:0]    z,
    input  logic [ZW-1:0]    s,
    output logic [Z_MAX-1:0] y
);
    function automatic logic [Z_MAX-1:0] rot_step(logic [Z_MAX-1:0] v,
                                                  logic [ZW-1:0] zz, int amt);
        logic [Z_MAX-1:0] r;
        int j;
        for (int i = 0; i < Z_MAX; i++) begin
            j = i + amt;
            if (j >= int'(zz)) j = j - int'(zz);
            r[i] = (i < int'(zz) && j >= 0 && j < Z_MAX) ? v[j] : 1'b0;
        end
        return r;
    endfunction

    function automatic logic [Z_MAX-1:0] low_mask(logic [ZW-1:0] zz);
        logic [Z_MAX-1:0] m;
        for (int i = 0; i < Z_MAX; i++) m[i] = (i < int'(zz));
        return m;
    endfunction

    logic [Z_MAX-1:0] stg [ZW+1];

    assign stg[0] = x & low_mask(z);

    for (genvar k = 0; k < ZW; k++) begin : g_stage
        assign stg[k+1] = s[k] ? rot_step(stg[k], z, 1 << k) : stg[k];
    end

    assign y = stg[ZW];
endmodule

// File: rtl/ldpc_lambda_acc.sv
module ldpc_lambda_acc
    import ldpc_lambda_pkg::*;
#(
    parameter int Z_MAX  = Z_MAX_DEF,
    parameter int MB     = MB_DEF,
    parameter int KB_MAX = KB_MAX_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [1:0]            rate_sel,
    input  logic [4:0]            z_sel,
    input  logic                  in_valid,
    input  logic [Z_MAX-1:0]      in_data,
    output logic [MB*Z_MAX-1:0]   lambda_out,
    output logic                  done
);
    localparam int ZW = $clog2(Z_MAX + 1);
    localparam int CW = $clog2(KB_MAX + 1);

    rate_e            rate_q;
    logic [ZW-1:0]    z_cur;
    logic [CW-1:0]    col_q;
    logic             busy;
    logic [Z_MAX-1:0] lam     [MB];
    logic [Z_MAX-1:0] contrib [MB];
    logic             last_col;

    assign last_col = (int'(col_q) == kb_of(rate_q) - 1);

    for (genvar m = 0; m < MB; m++) begin : g_row
        base_ent_t        ent;
        logic [ZW-1:0]    shamt;
        logic [Z_MAX-1:0] rotated;

        assign ent = base_lookup(rate_q, m, int'(col_q));

        ldpc_shift_scale #(.ZW(ZW)) scale_i (
            .p        (ent.p),
            .z        (z_cur),
            .mod_mode (rate_q == RATE_TWO3_A),
            .s        (shamt)
        );

        ldpc_rotor #(.Z_MAX(Z_MAX), .ZW(ZW)) rot_i (
            .x (in_data),
            .z (z_cur),
            .s (shamt),
            .y (rotated)
        );

        assign contrib[m] = ent.present ? rotated : '0;
        assign lambda_out[m*Z_MAX +: Z_MAX] = lam[m];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= RATE_HALF;
            z_cur  <= ZW'(Z_MIN);
            col_q  <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
            for (int m = 0; m < MB; m++) lam[m] <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rate_q <= rate_e'(rate_sel);
                z_cur  <= ZW'(z_of(z_sel));
                col_q  <= '0;
                busy   <= 1'b1;
                for (int m = 0; m < MB; m++) lam[m] <= '0;
            end else if (busy && in_valid) begin
                for (int m = 0; m < MB; m++) lam[m] <= lam[m] ^ contrib[m];
                col_q <= col_q + 1'b1;
                if (last_col) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ldpc_lambda_chk.sv
module ldpc_lambda_chk #(
    parameter int Z_MAX = 96,
    parameter int MB    = 4,
    parameter int ZW    = 7
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                in_valid,
    input logic                done,
    input logic [MB*Z_MAX-1:0] lambda_out,
    input logic [ZW-1:0]       z_cur
);
    logic [Z_MAX-1:0]    row_mask;
    logic [MB*Z_MAX-1:0] full_mask;

    always_comb begin
        for (int i = 0; i < Z_MAX; i++) row_mask[i] = (i < int'(z_cur));
        full_mask = {MB{row_mask}};
    end

    assert_start_clears_R1: assert property (@(posedge clk) disable iff (rst)
        start |=> (lambda_out == '0));

    assert_high_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (lambda_out & ~full_mask) == '0);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_follows_valid_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid));

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !start) |=> $stable(lambda_out));
endmodule

bind ldpc_lambda_acc ldpc_lambda_chk #(.Z_MAX(Z_MAX), .MB(MB), .ZW(ZW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .in_valid   (in_valid),
    .done       (done),
    .lambda_out (lambda_out),
    .z_cur      (z_cur)
);

// File: tb/ldpc_lambda_acc_tb.sv
module ldpc_lambda_acc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ZM = 96;
    localparam int NR = 4;
    localparam int NCASE = 6;
    localparam int CASES [NCASE][3] = '{
        '{0, 0, 101}, '{1, 7, 202}, '{2, 18, 303},
        '{3, 5, 404}, '{1, 18, 505}, '{0, 12, 606}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [1:0]        rate_sel = '0;
    logic [4:0]        z_sel = '0;
    logic              in_valid = 1'b0;
    logic [ZM-1:0]     in_data = '0;
    logic [NR*ZM-1:0]  lambda_out;
    logic              done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    ldpc_lambda_acc dut_i (
        .clk(clk), .rst(rst), .start(start), .rate_sel(rate_sel), .z_sel(z_sel),
        .in_valid(in_valid), .in_data(in_data), .lambda_out(lambda_out), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mix(logic [31:0] v);
        logic [31:0] t;
        t = v;
        t = t ^ (t << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic logic [ZM-1:0] gen(int seed, int col);
        logic [31:0] a, b, c;
        a = mix(32'(seed) * 32'd2654435761 + 32'(col) * 32'd40503 + 32'd1);
        b = mix(a ^ 32'h5bd1e995);
        c = mix(b + 32'h9e3779b9);
        return {c, b, a};
    endfunction

    function automatic int kb_exp(int rate);
        return (rate == 0) ? 4 : (rate == 1) ? 8 : (rate == 2) ? 12 : 20;
    endfunction

    function automatic logic [ZM-1:0] exp_row(int rate, int zsel, int seed,
                                              int row, int ncols);
        logic [ZM-1:0] acc;
        logic [ZM-1:0] d;
        int z, p, s;
        acc = '0;
        z = 24 + 4 * ((zsel > 18) ? 18 : zsel);
        for (int c = 0; c < ncols; c++) begin
            if (((row + c + rate) % 3) != 0) begin
                p = (37 * row + 53 * c + 11 * rate + 5) % 96;
                s = (rate == 1) ? (p % z) : ((p * z) / 96);
                d = gen(seed, c);
                for (int i = 0; i < z; i++) acc[i] = acc[i] ^ d[(i + s) % z];
            end
        end
        return acc;
    endfunction

    task automatic check(string req, logic [ZM-1:0] act, logic [ZM-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_rows(string req, int rate, int zsel, int seed, int ncols);
        for (int m = 0; m < NR; m++)
            check(req, lambda_out[m*ZM +: ZM], exp_row(rate, zsel, seed, m, ncols));
    endtask

    task automatic open_frame(int rate, int zsel);
        @(negedge clk);
        start = 1'b1;
        rate_sel = 2'(rate);
        z_sel = 5'(zsel);
        in_valid = 1'b1;
        in_data = '1;
        @(negedge clk);
        start = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic feed(int rate, int seed, int ncols, bit gaps);
        int kb;
        bit early;
        kb = kb_exp(rate);
        early = 1'b0;
        for (int c = 0; c < ncols; c++) begin
            if (gaps && (c % 2 == 1)) begin
                in_valid = 1'b0;
                in_data = '1;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data = gen(seed, c);
            @(negedge clk);
            if (c < kb - 1 && done) early = 1'b1;
            if (c == kb - 1) begin
                check("R7 done at last column", ZM'(done), ZM'(1));
                check("R7 no early done", ZM'(early), ZM'(0));
            end
        end
        in_valid = 1'b0;
        if (ncols == kb) begin
            @(negedge clk);
            check("R7 done pulse width", ZM'(done), ZM'(0));
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                report();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 reset lambda row0", lambda_out[0 +: ZM], '0);
        check("R10 reset lambda row3", lambda_out[3*ZM +: ZM], '0);
        check("R10 reset done", ZM'(done), ZM'(0));

        // R8 strobes before any start
        in_valid = 1'b1;
        in_data = gen(7, 0);
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        check("R8 idle strobe ignored", lambda_out[ZM +: ZM], '0);
        check("R8 idle strobe no done", ZM'(done), ZM'(0));

        // table-driven frames (R3 R4 R5 R6)
        for (int k = 0; k < NCASE; k++) begin
            open_frame(CASES[k][0], CASES[k][1]);
            check("R1 cleared after start", lambda_out[2*ZM +: ZM], '0);
            feed(CASES[k][0], CASES[k][2], kb_exp(CASES[k][0]), 1'b0);
            check_rows("R3 R4 R5 lambda", CASES[k][0], CASES[k][1], CASES[k][2],
                       kb_exp(CASES[k][0]));
        end

        // R8 strobes after a complete frame
        in_valid = 1'b1;
        in_data = gen(9, 3);
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
        check_rows("R8 post-frame hold", 0, 12, 606, 4);

        // R6 gaps between columns
        open_frame(2, 9);
        feed(2, 777, 12, 1'b1);
        check_rows("R6 gapped columns", 2, 9, 777, 12);

        // R9 abort mid-frame then restart
        open_frame(3, 18);
        feed(3, 888, 5, 1'b0);
        check("R9 no done on partial", ZM'(done), ZM'(0));
        open_frame(0, 3);
        check("R1 restart clears", lambda_out[0 +: ZM], '0);
        feed(0, 999, 4, 1'b0);
        check_rows("R9 restart result", 0, 3, 999, 4);

        // R2 out-of-range length select behaves as Z=96
        open_frame(3, 25);
        feed(3, 1212, 20, 1'b0);
        check_rows("R2 z_sel clamp", 3, 18, 1212, 20);

        // R2 high input bits ignored at Z=24 (data is full width)
        open_frame(1, 0);
        feed(1, 1313, 8, 1'b0);
        check_rows("R2 high bits masked", 1, 0, 1313, 8);

        report();
    end
endmodule